// File: doc/BRIEF.md
# Line Driver Gain and Power Sequencer

This block sits on the host side of a programmable-gain cable line driver. It takes simple requests from system logic and turns them into the driver's control pins. A request can write a gain code, turn transmission on or off, move the driver into or out of low-power mode, save the current gain code into a memory slot, or replay a saved code. A gain write becomes one serial frame. The frame drops an active-low load strobe, shifts eight bits out most-significant first against a generated serial clock, and then raises the strobe so the driver latches the word.

Every serial phase lasts a parameterised number of system clock cycles (`HALF_CYC`), so the interface's minimum widths and setup times hold at any system clock rate. The block also enforces a safe power-up order: transmit stays off until at least one gain frame has completed. A `busy` flag covers the whole frame. An `ack` pulse reports that each request has finished.

Top module: `ldrv_seq`

## Requirements
- R1: After reset `latchN`=1, `serClk`=0, `txOn`=0, `runMode`=1 and `busy`=0.
- R2: A transmit-on request (op 1, arg bit0=1) leaves `txOn` at 0 until at least one gain frame has completed since reset. After that, op 1 sets `txOn` to arg bit0.
- R3: A gain request (op 0) produces exactly one frame. `latchN` falls, eight bits follow on `serDat`, each captured on a rising `serClk`, most-significant bit first, and then `latchN` rises. The 8-bit word sent is the requested code.
- R4: With a 5 ns system clock and HALF_CYC=4, the frame meets these minimums: serial clock high and low each ≥16 ns, `serDat` stable ≥5 ns before and after each rising edge, `latchN` low ≥15 ns before the first rising edge, and `latchN` rising ≥3 ns after the last falling edge.
- R5: `serClk` stays low and `serDat` is don't-care whenever `latchN` is high.
- R6: Op 2 with arg bit0=1 drives `runMode` to 0 (low power). Op 2 with arg bit0=0 drives it back to 1 (normal).
- R7: Gain codes above 79 are clamped, so the frame carries 79. Codes 0..79 pass through unchanged.
- R8: `busy` is 1 from the cycle after a frame request is accepted until the frame completes. Requests presented while `busy` is 1 are ignored: they produce no frame, no ack and no state change.
- R9: `ack` is a single-cycle pulse. A frame request gets its pulse after `latchN` has risen. Ops 1, 2 and 3 get theirs in the cycle after acceptance.
- R10: Op 3 stores the current gain code into slot arg bit0. Op 4 recalls slot arg bit0 and sends it as a full gain frame. Both slots reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqOp | input | 3 | 0 gain, 1 transmit, 2 low power, 3 store, 4 recall |
| reqArg | input | 8 | Gain code, or bit0 as level or slot |
| busy | output | 1 | Serial frame in progress |
| ack | output | 1 | One-cycle completion pulse |
| latchN | output | 1 | Active-low serial load strobe; rising edge latches |
| serClk | output | 1 | Serial clock to the driver |
| serDat | output | 1 | Serial data, MSB first |
| txOn | output | 1 | Transmit enable, 1 = transmit |
| runMode | output | 1 | 0 = low-power mode, 1 = normal |

## Verification
The bench first asks for transmit before any gain frame has been sent. A sequencer without the power-up interlock would raise `txOn` while the driver's gain is still undefined. It then sends out-of-range codes just above and far above 79. A missing clamp would put an invalid word on the wire. A gain request is issued in the middle of a frame: without blocking, that request would either corrupt the shift register or produce a second frame and a second ack. Edge-to-edge times are measured on the serial pins, which exposes short setup windows or data that changes near the rising edge. Store and recall are checked across two slots, which catches swapped slots or a recall that never reaches the wire.

// File: rtl/ldrv_pkg.sv
package ldrv_pkg;
  typedef enum logic [2:0] {
    OP_GAIN   = 3'd0,
    OP_TXEN   = 3'd1,
    OP_SLEEP  = 3'd2,
    OP_STORE  = 3'd3,
    OP_RECALL = 3'd4
  } reqOp_e;

  // strobes from control to the serial datapath
  typedef struct packed {
    logic load;   // open frame: drop strobe, load word
    logic rise;   // serial clock high
    logic fall;   // serial clock low, advance data
    logic close;  // raise strobe to latch
  } serStb_t;
endpackage

// File: rtl/ldrv_shift.sv
module ldrv_shift
  import ldrv_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStb_t           stb,
  input  logic [WORD_W-1:0] frameWord,
  output logic              latchN,
  output logic              serClk,
  output logic              serDat
);
  logic [WORD_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      serClk <= 1'b0;
      latchN <= 1'b1;
    end else begin
      if (stb.load) begin
        shReg  <= frameWord;
        latchN <= 1'b0;
      end
      if (stb.rise) serClk <= 1'b1;
      if (stb.fall) begin
        serClk <= 1'b0;
        shReg  <= {shReg[WORD_W-2:0], 1'b0};
      end
      if (stb.close) latchN <= 1'b1;
    end
  end

  assign serDat = shReg[WORD_W-1];

  AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    latchN |-> !serClk) else $error("serial clock active outside frame"); // R5
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(shReg)) else $error("data moved while clock high"); // R4
  AST_NO_NESTED_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> latchN) else $error("frame opened inside frame"); // R8
endmodule

// File: rtl/ldrv_ctrl.sv
module ldrv_ctrl
  import ldrv_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int WORD_W   = 8,
  parameter int SLOTS    = 2,
  parameter int GAIN_MAX = 79
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [WORD_W-1:0] reqArg,
  output logic              busy,
  output logic              ack,
  output logic              txOn,
  output logic              runMode,
  output logic [WORD_W-1:0] frameWord,
  output serStb_t           stb
);
  localparam int TMR_W  = $clog2(HALF_CYC + 1);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [TMR_W-1:0]  TMR_LOAD = TMR_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [WORD_W-1:0] CODE_TOP = WORD_W'(GAIN_MAX);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HI, S_LO, S_HOLD} state_e;

  state_e            state;
  logic [TMR_W-1:0]  tmr;
  logic [BIT_W-1:0]  bitCnt;
  logic              gainValid;
  logic [WORD_W-1:0] curGain;
  logic [WORD_W-1:0] slotMem [SLOTS];
  logic [SLOT_W-1:0] slotSel;
  logic              slotOk, tmrDone, startFrame;
  logic [WORD_W-1:0] clampCode, slotWord;
  reqOp_e            op;

  assign op        = reqOp_e'(reqOp);
  assign slotSel   = reqArg[SLOT_W-1:0];
  assign slotOk    = (int'(slotSel) < SLOTS);
  assign slotWord  = slotOk ? slotMem[slotSel] : '0;
  assign clampCode = (reqArg > CODE_TOP) ? CODE_TOP : reqArg;
  assign tmrDone   = (tmr == '0);
  assign busy      = (state != S_IDLE);
  assign startFrame = (state == S_IDLE) && reqValid &&
                      ((op == OP_GAIN) || (op == OP_RECALL));
  assign frameWord = (op == OP_GAIN) ? clampCode : slotWord;

  always_comb begin
    stb       = '0;
    stb.load  = startFrame;
    stb.rise  = tmrDone && ((state == S_SETUP) ||
                ((state == S_LO) && (bitCnt != BIT_LAST)));
    stb.fall  = tmrDone && (state == S_HI);
    stb.close = tmrDone && (state == S_LO) && (bitCnt == BIT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      tmr       <= '0;
      bitCnt    <= '0;
      ack       <= 1'b0;
      txOn      <= 1'b0;
      runMode   <= 1'b1;
      gainValid <= 1'b0;
      curGain   <= '0;
      for (int i = 0; i < SLOTS; i++) slotMem[i] <= '0;
    end else begin
      ack <= 1'b0;
      unique case (state)
        S_IDLE: if (reqValid) begin
          if (startFrame) begin
            curGain <= frameWord;
            state   <= S_SETUP;
            tmr     <= TMR_LOAD;
            bitCnt  <= '0;
          end else begin
            ack <= 1'b1;
            case (op)
              OP_TXEN:  txOn    <= reqArg[0] & gainValid;
              OP_SLEEP: runMode <= ~reqArg[0];
              OP_STORE: if (slotOk) slotMem[slotSel] <= curGain;
              default: ;
            endcase
          end
        end
        S_SETUP: if (tmrDone) begin state <= S_HI; tmr <= TMR_LOAD; end
                 else tmr <= tmr - 1'b1;
        S_HI:    if (tmrDone) begin state <= S_LO; tmr <= TMR_LOAD; end
                 else tmr <= tmr - 1'b1;
        S_LO:    if (tmrDone) begin
                   tmr <= TMR_LOAD;
                   if (bitCnt == BIT_LAST) state <= S_HOLD;
                   else begin bitCnt <= bitCnt + 1'b1; state <= S_HI; end
                 end else tmr <= tmr - 1'b1;
        S_HOLD:  if (tmrDone) begin
                   state     <= S_IDLE;
                   ack       <= 1'b1;
                   gainValid <= 1'b1;
                 end else tmr <= tmr - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_TX_AFTER_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    txOn |-> gainValid) else $error("transmit before gain loaded"); // R2
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack) else $error("ack wider than one cycle"); // R9
  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    curGain <= CODE_TOP) else $error("gain code out of range"); // R7
  AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(curGain)) else $error("request taken while busy"); // R8
endmodule

// File: rtl/ldrv_seq.sv
module ldrv_seq
  import ldrv_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int WORD_W   = 8,
  parameter int SLOTS    = 2,
  parameter int GAIN_MAX = 79
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [WORD_W-1:0] reqArg,
  output logic              busy,
  output logic              ack,
  output logic              latchN,
  output logic              serClk,
  output logic              serDat,
  output logic              txOn,
  output logic              runMode
);
  serStb_t           stb;
  logic [WORD_W-1:0] frameWord;

  ldrv_ctrl #(.HALF_CYC(HALF_CYC), .WORD_W(WORD_W), .SLOTS(SLOTS), .GAIN_MAX(GAIN_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqArg(reqArg),
    .busy(busy), .ack(ack), .txOn(txOn), .runMode(runMode),
    .frameWord(frameWord), .stb(stb));

  ldrv_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rstN(rstN), .stb(stb), .frameWord(frameWord),
    .latchN(latchN), .serClk(serClk), .serDat(serDat));
endmodule

// File: tb/sim_ldrv_seq.sv
`timescale 1ns/1ps
module sim_ldrv_seq;
  localparam real CLK_P = 5.0;

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic [2:0] reqOp = 3'd0;
  logic [7:0] reqArg = 8'd0;
  logic busy, ack, latchN, serClk, serDat, txOn, runMode;

  int checks = 0, errors = 0;
  int frameCnt = 0, ackCnt = 0, ackWide = 0, viol = 0, bitSeen = 0, lastBits = 0;
  logic [7:0] capWord = '0, lastWord = '0;
  logic ackPrev = 1'b0, inFrame = 1'b0, firstRise = 1'b0;
  realtime tLatchFall = 0, tRise = -1000, tFall = -1000, tDat = -1000;

  always #(CLK_P/2) clk = ~clk;

  ldrv_seq u0 (.clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqArg(reqArg),
    .busy(busy), .ack(ack), .latchN(latchN), .serClk(serClk), .serDat(serDat),
    .txOn(txOn), .runMode(runMode));

  // pin-level frame capture and timing measurement (R3, R4, R5)
  always @(negedge latchN) begin
    tLatchFall = $realtime; firstRise = 1'b1; inFrame = 1'b1; bitSeen = 0;
  end
  always @(posedge serClk) begin
    if (latchN) viol++;
    if (firstRise && ($realtime - tLatchFall < 15.0)) viol++;
    if (!firstRise && ($realtime - tFall < 16.0)) viol++;
    if ($realtime - tDat < 5.0) viol++;
    firstRise = 1'b0; tRise = $realtime;
    capWord = {capWord[6:0], serDat}; bitSeen++;
  end
  always @(negedge serClk) begin
    if ($realtime - tRise < 16.0) viol++;
    tFall = $realtime;
  end
  always @(serDat) begin
    if (!latchN && ($realtime - tRise < 5.0)) viol++;
    tDat = $realtime;
  end
  always @(posedge latchN) if (inFrame) begin
    if ($realtime - tFall < 3.0) viol++;
    lastWord = capWord; lastBits = bitSeen; frameCnt++; inFrame = 1'b0;
  end
  always @(posedge clk) if (rstN) begin
    if (ack) ackCnt++;
    if (ack && ackPrev) ackWide++;
    ackPrev = ack;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [7:0] arg);
    int a0;
    @(negedge clk);
    while (busy) @(negedge clk);
    a0 = ackCnt;
    reqValid = 1'b1; reqOp = op; reqArg = arg;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 300 && ackCnt == a0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic gainWrite(input logic [7:0] code, input logic [7:0] exp, input string req);
    int f0 = frameCnt;
    send(3'd0, code);
    chk(frameCnt == f0 + 1, req, frameCnt - f0, 1);
    chk(lastBits == 8, req, lastBits, 8);
    chk(lastWord == exp, req, lastWord, exp);
  endtask

  task automatic tReset;
    chk(latchN === 1'b1, "R1 latchN", latchN, 1);
    chk(serClk === 1'b0, "R1 serClk", serClk, 0);
    chk(txOn === 1'b0, "R1 txOn", txOn, 0);
    chk(runMode === 1'b1, "R1 runMode", runMode, 1);
    chk(busy === 1'b0, "R1 busy", busy, 0);
  endtask

  task automatic tTxInterlock;
    send(3'd1, 8'd1);
    chk(txOn == 1'b0, "R2 tx before gain", txOn, 0);
    gainWrite(8'd37, 8'd37, "R3 gain 37");
    gainWrite(8'hA5 & 8'h3F, 8'h25, "R3 gain pattern");
    send(3'd1, 8'd1);
    chk(txOn == 1'b1, "R2 tx after gain", txOn, 1);
    send(3'd1, 8'd0);
    chk(txOn == 1'b0, "R2 tx off", txOn, 0);
  endtask

  task automatic tSleep;
    send(3'd2, 8'd1);
    chk(runMode == 1'b0, "R6 low power", runMode, 0);
    send(3'd2, 8'd0);
    chk(runMode == 1'b1, "R6 normal", runMode, 1);
  endtask

  task automatic tClamp;
    gainWrite(8'd79, 8'd79, "R7 code 79");
    gainWrite(8'd80, 8'd79, "R7 code 80");
    gainWrite(8'd255, 8'd79, "R7 code 255");
    gainWrite(8'd0, 8'd0, "R7 code 0");
  endtask

  task automatic tBusy;
    int f0 = frameCnt, a0 = ackCnt;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd0; reqArg = 8'd20;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R8 busy set", busy, 1);
    repeat (10) @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd0; reqArg = 8'd60;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd2; reqArg = 8'd1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 300 && busy; i++) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(frameCnt == f0 + 1, "R8 one frame", frameCnt - f0, 1);
    chk(lastWord == 8'd20, "R8 word kept", lastWord, 20);
    chk(ackCnt == a0 + 1, "R9 one ack", ackCnt - a0, 1);
    chk(runMode == 1'b1, "R8 sleep ignored", runMode, 1);
  endtask

  task automatic tMemory;
    int f0;
    gainWrite(8'd66, 8'd66, "R10 set 66");
    send(3'd3, 8'd0);
    gainWrite(8'd5, 8'd5, "R10 set 5");
    send(3'd3, 8'd1);
    f0 = frameCnt;
    send(3'd4, 8'd0);
    chk(frameCnt == f0 + 1, "R10 recall frame", frameCnt - f0, 1);
    chk(lastWord == 8'd66, "R10 recall slot0", lastWord, 66);
    send(3'd4, 8'd1);
    chk(lastWord == 8'd5, "R10 recall slot1", lastWord, 5);
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTxInterlock();
    tSleep();
    tClamp();
    tBusy();
    tMemory();
    chk(viol == 0, "R4 R5 pin timing", viol, 0);
    chk(ackWide == 0, "R9 ack width", ackWide, 0);
    finishRun();
  end
endmodule